// File: doc/BRIEF.md
# Controller Power-Up Reset Sequencer

This block brings a serial-link controller subsystem out of cold reset. After a start pulse it takes the subsystem from a fully reset, unclocked state to running in a fixed order. First it lifts the power and hot resets. Next it enables the application and reference clocks. It then lifts the PIPE, core, sticky and non-sticky resets and finally the active-low device reset that reaches the peripherals on the link. Two steps wait on reset-request inputs from the controller's embedded power manager. Each request passes through a two-flop synchronizer and is sampled once per poll period. A wait that does not clear within its timeout makes the block undo every completed step in reverse order, one per cycle. The block then reports an error.

The sequence progress is held as a single stage count. Every reset and clock-enable output is a threshold decode of that count. This makes the outputs always form an ordered prefix of the release list. All durations are given in microseconds and converted to cycles from the clock frequency parameter. Link training is never enabled by this block.

Top module: `pwrup_seq`

## Requirements
- R1: While rst_n is low the block forces a fixed state. All reset outputs are high, including both application resets. Both clock enables and dev_rst_n are low. busy, done and error are low. This takes effect at once, also in the middle of a sequence.
- R2: The release order is fixed, with one step per clock edge at most: power reset, hot reset, PHY reset, application clock enable, reference clock enable, PIPE reset, core reset, application resets, sticky reset, non-sticky reset, dev_rst_n. At every cycle the released items form a prefix of this list. Power release is the first edge after the edge that samples start. Hot release is the edge after that.
- R3: After the hot reset is released the block waits for phy_rst_req to go low. The request passes two flops before use. It is checked only on poll ticks, which come every CLK_MHZ*POLL_US cycles counted from the wait's entry. The PHY reset is released on the edge after the first tick that sees the synchronized request low.
- R4: The application clock enable rises on the edge after the PHY release, and the reference clock enable on the next edge. The block then waits in the same way on core_rst_req. The edge after a passing tick releases the PIPE reset, and the following edge releases the core reset.
- R5: app_mst_rst and app_slv_rst are identical. They stay asserted through the core reset release and for APP_HOLD_CYC+1 cycles after it, and are then released together.
- R6: done rises exactly SETTLE_US*CLK_MHZ cycles (SETTLE_US/POLL_US poll ticks) after dev_rst_n rises, and then stays high. A start pulse while done is high changes no output.
- R7: If a wait sees its request still high on its TIMEOUT_US/POLL_US-th tick, the block stops going forward and begins to unwind on that edge.
- R8: Unwinding re-asserts one completed item per clock edge in the reverse of the R2 order, ending with the power reset. error rises on the same edge the power reset returns, and all clock enables are then off.
- R9: A start pulse while error is high restarts the sequence from the first step and clears error on the edge that samples it.
- R10: busy is high from the edge that samples start until the edge that raises done or error. Exactly one of busy, done, error is high at a time, or none.
- R11: A start pulse while busy is high is ignored and leaves the timing of the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start | input | 1 | Launch pulse for the power-up sequence |
| phy_rst_req | input | 1 | Power-manager request to hold the PHY in reset (asynchronous) |
| core_rst_req | input | 1 | Power-manager request to hold the core in reset (asynchronous) |
| pwr_rst | output | 1 | Power reset, active high |
| hot_rst | output | 1 | Hot reset, active high |
| phy_rst | output | 1 | PHY reset, active high |
| pipe_rst | output | 1 | PIPE interface reset, active high |
| core_rst | output | 1 | Controller core reset, active high |
| sticky_rst | output | 1 | Sticky register reset, active high |
| nsticky_rst | output | 1 | Non-sticky register reset, active high |
| app_mst_rst | output | 1 | Application master-side reset, active high |
| app_slv_rst | output | 1 | Application slave-side reset, active high |
| app_clk_en | output | 1 | Application clock group enable |
| ref_clk_en | output | 1 | Reference/core clock enable |
| dev_rst_n | output | 1 | Active-low reset to the link peripherals |
| busy | output | 1 | Sequence or unwind in progress |
| done | output | 1 | Sequence completed and settled |
| error | output | 1 | A wait timed out and the sequence was unwound |

## Verification
A wrong stage count shows at the ports on the very next edge. An item is released or re-asserted out of turn, two items move together, or the prefix property breaks. The bench therefore inspects the whole output set on every cycle and records the edge at which each item changes. A wrong poll or settle counter, or a synchronizer with the wrong depth, moves a release by whole poll periods or by a single cycle. The bench compares each release edge, the timeout edge and the done edge with values it computes from the poll period, the hold length and the moment it drops each request.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    localparam int unsigned NUM_STAGES = 11;
    localparam int unsigned LVL_W      = 4;

    typedef logic [LVL_W-1:0] lvl_t;

    // Stage counts whose arrival starts a wait or a timed phase
    localparam lvl_t LV_HOT  = 4'd2;   // hot released -> PHY request wait
    localparam lvl_t LV_REF  = 4'd5;   // reference clock on -> core request wait
    localparam lvl_t LV_CORE = 4'd7;   // core released -> application hold
    localparam lvl_t LV_DEV  = 4'd11;  // device reset released -> settle

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_POLL,
        ST_HOLD,
        ST_SETTLE,
        ST_DONE,
        ST_UNWIND,
        ST_FAIL
    } seq_state_e;

endpackage

// File: rtl/pwrup_seq_sync.sv
module pwrup_seq_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, meta_d;
        logic safe_q, safe_d;

        always_comb begin
            meta_d = async_in[b];
            safe_d = meta_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                safe_q <= RST_VAL;
            end else begin
                meta_q <= meta_d;
                safe_q <= safe_d;
            end
        end

        assign sync_out[b] = safe_q;
    end

endmodule

// File: rtl/pwrup_seq_tick.sv
module pwrup_seq_tick #(
    parameter int unsigned PERIOD = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int unsigned TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
        tick  = !clr && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: consecutive ticks are PERIOD cycles apart, so no two adjacent cycles tick
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (PERIOD > 1 && tick) |=> !tick);

endmodule

// File: rtl/pwrup_seq_stage_map.sv
module pwrup_seq_stage_map #(
    parameter int unsigned NUM = 11,
    parameter int unsigned LW  = 4
) (
    input  logic [LW-1:0]  lvl,
    output logic [NUM-1:0] released
);

    // Item i is released once the stage count has passed it
    for (genvar i = 0; i < NUM; i++) begin : g_item
        assign released[i] = (lvl > LW'(i));
    end

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 200,
    parameter int unsigned POLL_US      = 1,
    parameter int unsigned TIMEOUT_US   = 1000,
    parameter int unsigned SETTLE_US    = 100,
    parameter int unsigned APP_HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic phy_rst_req,
    input  logic core_rst_req,
    output logic pwr_rst,
    output logic hot_rst,
    output logic phy_rst,
    output logic pipe_rst,
    output logic core_rst,
    output logic sticky_rst,
    output logic nsticky_rst,
    output logic app_mst_rst,
    output logic app_slv_rst,
    output logic app_clk_en,
    output logic ref_clk_en,
    output logic dev_rst_n,
    output logic busy,
    output logic done,
    output logic error
);

    localparam int unsigned TICK_CYC   = CLK_MHZ * POLL_US;
    localparam int unsigned TO_TICKS   = (TIMEOUT_US + POLL_US - 1) / POLL_US;
    localparam int unsigned ST_TICKS   = (SETTLE_US + POLL_US - 1) / POLL_US;
    localparam int unsigned MAX_TICKS  = (TO_TICKS > ST_TICKS) ? TO_TICKS : ST_TICKS;
    localparam int unsigned CW         = $clog2(MAX_TICKS + 1);
    localparam int unsigned HW         = (APP_HOLD_CYC > 1) ? $clog2(APP_HOLD_CYC) : 1;
    localparam int unsigned SETTLE_CYC = ST_TICKS * TICK_CYC;
    localparam int unsigned SCW        = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        seq_state_e    state;
        lvl_t          lvl;
        logic [CW-1:0] tcnt;
        logic [HW-1:0] hcnt;
    } seq_regs_t;

    seq_regs_t q, d;

    logic       tick, tick_clr;
    logic [1:0] req_s;
    logic       phy_req_s, core_req_s;
    logic       cur_req;
    lvl_t       lvl_inc;
    logic [NUM_STAGES-1:0] rel;

    pwrup_seq_sync #(.WIDTH(2), .RST_VAL(1'b1)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({core_rst_req, phy_rst_req}),
        .sync_out (req_s)
    );
    assign phy_req_s  = req_s[0];
    assign core_req_s = req_s[1];

    pwrup_seq_tick #(.PERIOD(TICK_CYC)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    pwrup_seq_stage_map #(.NUM(NUM_STAGES), .LW(LVL_W)) i_map (
        .lvl      (q.lvl),
        .released (rel)
    );

    // Next-state computation
    always_comb begin
        d        = q;
        lvl_inc  = q.lvl + 1'b1;
        tick_clr = (q.state == ST_STEP);
        cur_req  = (q.lvl == LV_HOT) ? phy_req_s : core_req_s;

        case (q.state)
            ST_IDLE, ST_FAIL: begin
                if (start) begin
                    d.state = ST_STEP;
                    d.lvl   = '0;
                end
            end
            ST_STEP: begin
                d.lvl  = lvl_inc;
                d.tcnt = '0;
                d.hcnt = '0;
                if (lvl_inc == LV_HOT || lvl_inc == LV_REF) begin
                    d.state = ST_POLL;
                end else if (lvl_inc == LV_CORE) begin
                    d.state = ST_HOLD;
                end else if (lvl_inc == LV_DEV) begin
                    d.state = ST_SETTLE;
                end else begin
                    d.state = ST_STEP;
                end
            end
            ST_POLL: begin
                if (tick) begin
                    if (!cur_req) begin
                        d.state = ST_STEP;
                    end else if (q.tcnt == CW'(TO_TICKS - 1)) begin
                        d.state = ST_UNWIND;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (q.hcnt == HW'(APP_HOLD_CYC - 1)) begin
                    d.state = ST_STEP;
                end else begin
                    d.hcnt = q.hcnt + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tick) begin
                    if (q.tcnt == CW'(ST_TICKS - 1)) begin
                        d.state = ST_DONE;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            ST_UNWIND: begin
                d.lvl = q.lvl - 1'b1;
                if (q.lvl == lvl_t'(1)) begin
                    d.state = ST_FAIL;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, lvl: '0, tcnt: '0, hcnt: '0};
        end else begin
            q <= d;
        end
    end

    // Output decode: each item is a threshold on the stage count
    assign pwr_rst     = !rel[0];
    assign hot_rst     = !rel[1];
    assign phy_rst     = !rel[2];
    assign app_clk_en  =  rel[3];
    assign ref_clk_en  =  rel[4];
    assign pipe_rst    = !rel[5];
    assign core_rst    = !rel[6];
    assign app_mst_rst = !rel[7];
    assign app_slv_rst = !rel[7];
    assign sticky_rst  = !rel[8];
    assign nsticky_rst = !rel[9];
    assign dev_rst_n   =  rel[10];

    assign done  = (q.state == ST_DONE);
    assign error = (q.state == ST_FAIL);
    assign busy  = (q.state == ST_STEP) || (q.state == ST_POLL) || (q.state == ST_HOLD)
                || (q.state == ST_SETTLE) || (q.state == ST_UNWIND);

    // Cycles since the device reset was lifted, saturating; feeds the settle check
    logic [SCW-1:0] settle_cnt_q, settle_cnt_d;
    always_comb begin
        settle_cnt_d = settle_cnt_q;
        if (!dev_rst_n) begin
            settle_cnt_d = '0;
        end else if (settle_cnt_q != SCW'(SETTLE_CYC)) begin
            settle_cnt_d = settle_cnt_q + 1'b1;
        end
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_cnt_q <= '0;
        end else begin
            settle_cnt_q <= settle_cnt_d;
        end
    end

    // R3: the PHY reset lifts only after a synchronized low request was seen
    a_r3_phy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst) |-> $past(!phy_req_s, 2));

    // R4: the PIPE reset lifts only after a synchronized low core request was seen
    a_r4_pipe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pipe_rst) |-> $past(!core_req_s, 2));

    // R2: never more than one item moves on an edge
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rel ^ $past(rel)) <= 1);

    // R6: done never precedes the full settle interval
    a_r6_settle_time: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (settle_cnt_q >= SCW'(SETTLE_CYC)));

    // R8: on failure everything is back in reset with clocks off
    a_r8_fail_all_reset: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (pwr_rst && hot_rst && !app_clk_en && !ref_clk_en && !dev_rst_n));

    // R10: status flags are mutually exclusive
    a_r10_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, error}));

    // R5: both application resets move together
    a_r5_app_pair: assert property (@(posedge clk) disable iff (!rst_n)
        app_mst_rst == app_slv_rst);

endmodule

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;

    localparam int T   = 4;   // CLK_MHZ * POLL_US
    localparam int TO  = 6;   // timeout ticks
    localparam int S   = 3;   // settle ticks
    localparam int H   = 2;   // application hold cycles
    localparam int RUN = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic phy_rst_req = 1'b1;
    logic core_rst_req = 1'b1;
    logic pwr_rst, hot_rst, phy_rst, pipe_rst, core_rst, sticky_rst, nsticky_rst;
    logic app_mst_rst, app_slv_rst, app_clk_en, ref_clk_en, dev_rst_n;
    logic busy, done, error;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwrup_seq #(
        .CLK_MHZ(T), .POLL_US(1), .TIMEOUT_US(TO), .SETTLE_US(S), .APP_HOLD_CYC(H)
    ) i_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .phy_rst_req(phy_rst_req), .core_rst_req(core_rst_req),
        .pwr_rst(pwr_rst), .hot_rst(hot_rst), .phy_rst(phy_rst), .pipe_rst(pipe_rst),
        .core_rst(core_rst), .sticky_rst(sticky_rst), .nsticky_rst(nsticky_rst),
        .app_mst_rst(app_mst_rst), .app_slv_rst(app_slv_rst),
        .app_clk_en(app_clk_en), .ref_clk_en(ref_clk_en), .dev_rst_n(dev_rst_n),
        .busy(busy), .done(done), .error(error)
    );

    int ev_rel[11];
    int ev_back[11];
    int ev_done, ev_err, err_first, viol_prefix, viol_busy, viol_app;

    function automatic logic [10:0] rel_vec();
        return {dev_rst_n, ~nsticky_rst, ~sticky_rst, ~app_mst_rst, ~core_rst, ~pipe_rst,
                ref_clk_en, app_clk_en, ~phy_rst, ~hot_rst, ~pwr_rst};
    endfunction

    // First poll tick index m whose decision edge base+T*m sees a request dropped at negedge r
    function automatic int tick_pass(input int base, input int r);
        int m = 1;
        while (base + T * m < r + 2) m++;
        return m;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " outputs"}, int'(rel_vec()), 0);
        chk({tag, " app resets"}, int'({app_mst_rst, app_slv_rst}), 3);
        chk({tag, " status"}, int'({busy, done, error}), 0);
    endtask

    // Drops phy/core requests at negedge phy_r/core_r (0 = low beforehand), extra start at x_st
    task automatic run(input int phy_r, input int core_r, input int x_st);
        logic [10:0] v;
        logic ended;
        for (int i = 0; i < 11; i++) begin
            ev_rel[i] = -1;
            ev_back[i] = -1;
        end
        ev_done = -1; ev_err = -1; err_first = -1;
        viol_prefix = 0; viol_busy = 0; viol_app = 0;
        ended = 1'b0;
        @(negedge clk);
        phy_rst_req  = (phy_r != 0);
        core_rst_req = (core_r != 0);
        repeat (3) @(negedge clk);
        start = 1'b1;
        for (int k = 1; k <= RUN; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start = 1'b0;
                err_first = int'(error);
            end
            v = rel_vec();
            for (int i = 0; i < 11; i++) begin
                if (v[i] && ev_rel[i] < 0) ev_rel[i] = k - 1;
                if (!v[i] && ev_rel[i] >= 0 && ev_back[i] < 0) ev_back[i] = k - 1;
                if (i > 0 && v[i] && !v[i-1]) viol_prefix++;
            end
            if (app_mst_rst != app_slv_rst) viol_app++;
            if (done && ev_done < 0) begin ev_done = k - 1; ended = 1'b1; end
            if (error && ev_err < 0 && k > 1) begin ev_err = k - 1; ended = 1'b1; end
            if (busy == ended) viol_busy++;
            if (k == x_st) start = 1'b1;
            if (k == x_st + 1) start = 1'b0;
            if (k == phy_r) phy_rst_req = 1'b0;
            if (k == core_r) core_rst_req = 1'b0;
        end
    endtask

    task automatic check_success(input string tag, input int phy_r, input int core_r);
        int ep, ec, dv;
        ep = 3 + T * tick_pass(2, phy_r);
        ec = ep + 2 + T * tick_pass(ep + 2, core_r);
        chk({tag, " R2 power release edge"}, ev_rel[0], 1);
        chk({tag, " R2 hot release edge"}, ev_rel[1], 2);
        chk({tag, " R3 phy release edge"}, ev_rel[2], ep);
        chk({tag, " R4 app clock edge"}, ev_rel[3], ep + 1);
        chk({tag, " R4 ref clock edge"}, ev_rel[4], ep + 2);
        chk({tag, " R4 pipe release edge"}, ev_rel[5], ec + 1);
        chk({tag, " R4 core release edge"}, ev_rel[6], ec + 2);
        chk({tag, " R5 app release edge"}, ev_rel[7], ec + 3 + H);
        chk({tag, " R2 sticky release edge"}, ev_rel[8], ec + 4 + H);
        chk({tag, " R2 nsticky release edge"}, ev_rel[9], ec + 5 + H);
        dv = ec + 6 + H;
        chk({tag, " R2 dev release edge"}, ev_rel[10], dv);
        chk({tag, " R6 done edge"}, ev_done, dv + S * T);
        chk({tag, " R2 prefix violations"}, viol_prefix, 0);
        chk({tag, " R5 app pair mismatches"}, viol_app, 0);
        chk({tag, " R10 busy violations"}, viol_busy, 0);
        chk({tag, " R8 no error"}, ev_err, -1);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int ep, u;
        // R1: state under reset
        #1;
        check_reset_state("R1 at power-on");
        do_reset();
        check_reset_state("R1 after reset");

        // Requests already low, extra start at k=5 ignored (R11)
        run(0, 0, 5);
        check_success("A R11", 0, 0);

        // R6: start while done has no effect
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R6 outputs kept after start in done", int'(rel_vec()), 11'h7ff);
        chk("R6 status kept after start in done", int'({busy, done, error}), 2);

        // PHY request drops late, core request never drops: timeout in core wait
        do_reset();
        run(9, RUN + 10, 0);
        ep = 3 + T * tick_pass(2, 9);
        chk("B R3 delayed phy release edge", ev_rel[2], ep);
        u = ep + 2 + T * TO;
        chk("B R7 pipe never released", ev_rel[5], -1);
        chk("B R8 ref clock off edge", ev_back[4], u + 1);
        chk("B R8 app clock off edge", ev_back[3], u + 2);
        chk("B R8 phy reasserted edge", ev_back[2], u + 3);
        chk("B R8 hot reasserted edge", ev_back[1], u + 4);
        chk("B R8 power reasserted edge", ev_back[0], u + 5);
        chk("B R8 error edge", ev_err, u + 5);
        chk("B R8 prefix violations", viol_prefix, 0);
        chk("B R10 busy violations", viol_busy, 0);

        // From error: restart, PHY request never drops
        run(RUN + 10, 0, 0);
        u = 2 + T * TO;
        chk("C R9 error cleared by start", err_first, 0);
        chk("C R7 phy never released", ev_rel[2], -1);
        chk("C R8 hot reasserted edge", ev_back[1], u + 1);
        chk("C R8 power reasserted edge", ev_back[0], u + 2);
        chk("C R8 error edge", ev_err, u + 2);

        // From error: full success
        run(0, 0, 0);
        chk("D R9 error cleared by start", err_first, 0);
        check_success("D R9", 0, 0);

        // Core request drops late
        do_reset();
        run(0, 20, 0);
        check_success("E R4", 0, 20);

        // R1: reset in the middle of a sequence
        do_reset();
        @(negedge clk); phy_rst_req = 1'b0; core_rst_req = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (12) @(negedge clk);
        chk("R1 mid-run progress before reset", int'(rel_vec() != 11'd0), 1);
        rst_n = 1'b0;
        #1;
        check_reset_state("R1 mid-run");
        @(negedge clk);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule